// File: doc/BRIEF.md
# Speculative Word-Dirty Line Buffer

This block sits beside an accelerator core and holds the core's writes while they are still speculative. Each resident line keeps a tag, a copy of its words and one mark bit per word. Only the words the core writes in the current window are marked, and so only those words count as uncommitted. A lookup on the read port returns the buffered value of a marked word. For any other word it passes through the fill data that the requester presents with the lookup.

A window ends in one of two ways. A squash drops every resident line and every mark in one cycle, so the core can rerun the window from its start. A commit makes every marked word permanent at once. The buffer then streams the marked words out on the drain port, one word per cycle, in the order the lines were first written and in ascending word order within a line. Once the last marked word has left, the buffer empties and the next window may begin. The number of lines is fixed. If a write names a line that is not resident and no slot is free, a sticky full flag rises and the write is refused until the window is resolved.

Top module: `spec_line_buf`

## Requirements
- R1: After reset, `full` and `drainValid` are low, and every read returns `fillData`.
- R2: A write accepted outside a drain sets the mark of the addressed word. A read of a marked word returns the most recent data written to it. A read of an unmarked word, or of a line that is not resident, returns `fillData` in the same cycle.
- R3: A squash while not draining clears all lines and marks in one cycle: `full` is low in the following cycle, no word is ever drained for that window, and later reads return `fillData`. Squash has priority when commit is high in the same cycle.
- R4: A commit while not draining starts the drain in the next cycle. A write presented in the commit cycle, or during the drain, is ignored. A squash raised during the drain is ignored.
- R5: The drain presents exactly one marked word per cycle with `drainValid` high. Lines come in the order of their first write in the window, and words within a line in ascending index order. Every marked word appears exactly once. After the last word the buffer is empty and reads return `fillData`.
- R6: Several writes to the same word within a window produce one drained word, carrying the last value written.
- R7: Once `NUM_LINES` distinct lines are resident, a write to another line raises `full`. That write is refused: its data is neither read back nor drained. `full` stays high until the window is resolved. Writes to lines already resident are still accepted.
- R8: `full` is low in the cycle after a commit or a squash.
- R9: During the drain, a read of a word not yet drained returns its committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Speculative write strobe |
| wrLine | input | LINE_AW | Line address of the write |
| wrWord | input | log2(WORDS) | Word index within the line |
| wrData | input | DATA_W | Write data |
| rdLine | input | LINE_AW | Line address of the lookup |
| rdWord | input | log2(WORDS) | Word index of the lookup |
| fillData | input | DATA_W | Data returned for unmarked words |
| rdData | output | DATA_W | Lookup result (combinational) |
| commit | input | 1 | Resolve the window as commit |
| squash | input | 1 | Resolve the window as squash |
| full | output | 1 | Sticky flag: a new-line write found no free slot |
| drainValid | output | 1 | A committed word is on the drain port |
| drainLine | output | LINE_AW | Line address of the drained word |
| drainWord | output | log2(WORDS) | Word index of the drained word |
| drainData | output | DATA_W | Drained data |

## Verification
The hardest situations to reach are the ones where window resolution overlaps other activity: a squash or a write arriving while a drain is in progress, or commit and squash raised together. Random traffic almost never lines these up. The stimulus reaches them with directed windows that raise those strobes on chosen drain cycles. Random windows spread writes over more distinct lines than the buffer holds, so the full condition and the refused writes come up often. Repeated hits on the same words exercise the drain ordering and de-duplication, and each drain is checked word by word against an ordered list built from a bench model.

// File: rtl/spec_line_buf_pkg.sv
package spec_line_buf_pkg;

  typedef enum logic {
    ST_OPEN  = 1'b0,
    ST_DRAIN = 1'b1
  } bufState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic doWrite;    // write into a resident line
    logic allocate;   // claim the next slot for a new line
    logic squashAll;  // drop every line and mark
    logic drainPop;   // retire the selected drain word
    logic clearAll;   // drain finished, release all lines
  } dpCtrl_t;

endpackage

// File: rtl/spec_line_buf_ctrl.sv
module spec_line_buf_ctrl
  import spec_line_buf_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          commit,
  input  logic                          squash,
  input  logic                          wrHit,
  input  logic                          anyDirty,
  output dpCtrl_t                       ctrl,
  output logic [$clog2(NUM_LINES)-1:0]  allocSlot,
  output logic                          full,
  output logic                          draining
);

  localparam int SLOT_W = $clog2(NUM_LINES);
  localparam int CNT_W  = $clog2(NUM_LINES + 1);
  localparam logic [CNT_W-1:0] LINES_C = CNT_W'(NUM_LINES);

  bufState_t        stateQ;
  logic [CNT_W-1:0] nextSlotQ;
  logic             fullQ;
  logic             slotFree;

  assign slotFree  = (nextSlotQ < LINES_C);
  assign allocSlot = nextSlotQ[SLOT_W-1:0];
  assign full      = fullQ;
  assign draining  = (stateQ == ST_DRAIN);

  always_comb begin
    ctrl = '0;
    if (stateQ == ST_OPEN) begin
      if (squash) begin
        ctrl.squashAll = 1'b1;
      end else if (!commit && wrEn) begin
        if (wrHit)
          ctrl.doWrite = 1'b1;
        else if (slotFree)
          ctrl.allocate = 1'b1;
      end
    end else begin
      if (anyDirty)
        ctrl.drainPop = 1'b1;
      else
        ctrl.clearAll = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_OPEN;
      nextSlotQ <= '0;
      fullQ     <= 1'b0;
    end else if (stateQ == ST_OPEN) begin
      if (squash) begin
        nextSlotQ <= '0;
        fullQ     <= 1'b0;
      end else if (commit) begin
        stateQ <= ST_DRAIN;
        fullQ  <= 1'b0;
      end else if (wrEn && !wrHit) begin
        if (slotFree)
          nextSlotQ <= nextSlotQ + 1'b1;
        else
          fullQ <= 1'b1;
      end
    end else begin
      if (!anyDirty) begin
        stateQ    <= ST_OPEN;
        nextSlotQ <= '0;
      end
    end
  end

endmodule

// File: rtl/spec_line_buf_dp.sv
module spec_line_buf_dp
  import spec_line_buf_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WORDS     = 4,
  parameter int LINE_AW   = 12,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtrl_t                       ctrl,
  input  logic [$clog2(NUM_LINES)-1:0]  allocSlot,
  input  logic [LINE_AW-1:0]            wrLine,
  input  logic [$clog2(WORDS)-1:0]      wrWord,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [LINE_AW-1:0]            rdLine,
  input  logic [$clog2(WORDS)-1:0]      rdWord,
  input  logic [DATA_W-1:0]             fillData,
  output logic [DATA_W-1:0]             rdData,
  output logic                          wrHit,
  output logic                          anyDirty,
  output logic [LINE_AW-1:0]            drainLine,
  output logic [$clog2(WORDS)-1:0]      drainWord,
  output logic [DATA_W-1:0]             drainData
);

  localparam int SLOT_W = $clog2(NUM_LINES);
  localparam int WIDX_W = $clog2(WORDS);

  logic [LINE_AW-1:0] tagQ  [NUM_LINES];
  logic [DATA_W-1:0]  dataQ [NUM_LINES][WORDS];
  logic [WORDS-1:0]   maskQ [NUM_LINES];
  logic [NUM_LINES-1:0] validQ;

  logic [SLOT_W-1:0] wrSlot, rdSlot, drSlot;
  logic              rdHit;
  logic [WIDX_W-1:0] drWord;

  // Tag match for the write port
  always_comb begin
    wrHit  = 1'b0;
    wrSlot = '0;
    for (int s = 0; s < NUM_LINES; s++) begin
      if (validQ[s] && tagQ[s] == wrLine) begin
        wrHit  = 1'b1;
        wrSlot = SLOT_W'(s);
      end
    end
  end

  // Tag match for the read port, marked words override the fill data
  always_comb begin
    rdHit  = 1'b0;
    rdSlot = '0;
    for (int s = 0; s < NUM_LINES; s++) begin
      if (validQ[s] && tagQ[s] == rdLine) begin
        rdHit  = 1'b1;
        rdSlot = SLOT_W'(s);
      end
    end
    if (rdHit && maskQ[rdSlot][rdWord])
      rdData = dataQ[rdSlot][rdWord];
    else
      rdData = fillData;
  end

  // Drain pick: lowest slot first, then lowest word
  always_comb begin
    anyDirty = 1'b0;
    drSlot   = '0;
    drWord   = '0;
    for (int s = NUM_LINES - 1; s >= 0; s--) begin
      for (int w = WORDS - 1; w >= 0; w--) begin
        if (maskQ[s][w]) begin
          anyDirty = 1'b1;
          drSlot   = SLOT_W'(s);
          drWord   = WIDX_W'(w);
        end
      end
    end
  end

  assign drainLine = tagQ[drSlot];
  assign drainWord = drWord;
  assign drainData = dataQ[drSlot][drWord];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int s = 0; s < NUM_LINES; s++) begin
        tagQ[s]  <= '0;
        maskQ[s] <= '0;
        for (int w = 0; w < WORDS; w++)
          dataQ[s][w] <= '0;
      end
    end else if (ctrl.squashAll || ctrl.clearAll) begin
      validQ <= '0;
      for (int s = 0; s < NUM_LINES; s++)
        maskQ[s] <= '0;
    end else begin
      if (ctrl.doWrite) begin
        dataQ[wrSlot][wrWord] <= wrData;
        maskQ[wrSlot][wrWord] <= 1'b1;
      end
      if (ctrl.allocate) begin
        validQ[allocSlot]         <= 1'b1;
        tagQ[allocSlot]           <= wrLine;
        dataQ[allocSlot][wrWord]  <= wrData;
        maskQ[allocSlot]          <= WORDS'(1) << wrWord;
      end
      if (ctrl.drainPop)
        maskQ[drSlot][drWord] <= 1'b0;
    end
  end

endmodule

// File: rtl/spec_line_buf.sv
module spec_line_buf
  import spec_line_buf_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WORDS     = 4,
  parameter int LINE_AW   = 12,
  parameter int DATA_W    = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [LINE_AW-1:0]        wrLine,
  input  logic [$clog2(WORDS)-1:0]  wrWord,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [LINE_AW-1:0]        rdLine,
  input  logic [$clog2(WORDS)-1:0]  rdWord,
  input  logic [DATA_W-1:0]         fillData,
  output logic [DATA_W-1:0]         rdData,
  input  logic                      commit,
  input  logic                      squash,
  output logic                      full,
  output logic                      drainValid,
  output logic [LINE_AW-1:0]        drainLine,
  output logic [$clog2(WORDS)-1:0]  drainWord,
  output logic [DATA_W-1:0]         drainData
);

  localparam int SLOT_W = $clog2(NUM_LINES);

  dpCtrl_t           ctrl;
  logic [SLOT_W-1:0] allocSlot;
  logic              wrHit;
  logic              anyDirty;
  logic              draining;

  spec_line_buf_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .commit(commit), .squash(squash),
    .wrHit(wrHit), .anyDirty(anyDirty), .ctrl(ctrl), .allocSlot(allocSlot),
    .full(full), .draining(draining)
  );

  spec_line_buf_dp #(
    .NUM_LINES(NUM_LINES), .WORDS(WORDS), .LINE_AW(LINE_AW), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .allocSlot(allocSlot),
    .wrLine(wrLine), .wrWord(wrWord), .wrData(wrData),
    .rdLine(rdLine), .rdWord(rdWord), .fillData(fillData), .rdData(rdData),
    .wrHit(wrHit), .anyDirty(anyDirty),
    .drainLine(drainLine), .drainWord(drainWord), .drainData(drainData)
  );

  assign drainValid = draining && anyDirty;

endmodule

// File: rtl/spec_line_buf_chk.sv
module spec_line_buf_chk (
  input logic clk,
  input logic rstN,
  input logic commit,
  input logic squash,
  input logic full,
  input logic drainValid,
  input logic draining
);

  // R3: squash outside a drain leaves nothing to drain and full low
  p_squash_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (squash && !draining) |=> (!draining && !drainValid && !full));

  // R4: a commit alone starts the drain on the next cycle
  p_commit_drains_r4: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !squash && !draining) |=> draining);

  // R5: drain words appear only while draining
  p_drain_in_state_r5: assert property (@(posedge clk) disable iff (!rstN)
    drainValid |-> draining);

  // R5: once no marked word remains the drain ends
  p_drain_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (draining && !drainValid) |=> !draining);

  // R7: full is sticky until the window is resolved
  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (full && !commit && !squash) |=> full);

  // R8: resolution clears full
  p_full_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((commit || squash) && !draining) |=> !full);

  // R7: full is never high during a drain
  p_full_not_drain_r7: assert property (@(posedge clk) disable iff (!rstN)
    draining |-> !full);

endmodule

bind spec_line_buf spec_line_buf_chk u_chk (
  .clk(clk), .rstN(rstN), .commit(commit), .squash(squash),
  .full(full), .drainValid(drainValid), .draining(draining)
);

// File: tb/spec_line_buf_tb.sv
module spec_line_buf_tb;

  localparam int NL = 4;
  localparam int NW = 4;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrLine = '0;
  logic [1:0] wrWord = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdLine = '0;
  logic [1:0] rdWord = '0;
  logic [DW-1:0] fillData = '0;
  logic [DW-1:0] rdData;
  logic commit = 1'b0;
  logic squash = 1'b0;
  logic full, drainValid;
  logic [AW-1:0] drainLine;
  logic [1:0] drainWord;
  logic [DW-1:0] drainData;

  int nChecks = 0;
  int nFails = 0;

  // Bench model of the window
  int mCount;
  bit mFull;
  logic [AW-1:0] mTag [NL];
  logic [DW-1:0] mData [NL][NW];
  bit mMask [NL][NW];

  always #4 clk = ~clk;

  spec_line_buf #(.NUM_LINES(NL), .WORDS(NW), .LINE_AW(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrLine(wrLine), .wrWord(wrWord),
    .wrData(wrData), .rdLine(rdLine), .rdWord(rdWord), .fillData(fillData),
    .rdData(rdData), .commit(commit), .squash(squash), .full(full),
    .drainValid(drainValid), .drainLine(drainLine), .drainWord(drainWord),
    .drainData(drainData)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    mCount = 0;
    mFull = 0;
    for (int s = 0; s < NL; s++)
      for (int w = 0; w < NW; w++) mMask[s][w] = 0;
  endtask

  function automatic int findSlot(logic [AW-1:0] line);
    for (int s = 0; s < mCount; s++)
      if (mTag[s] == line) return s;
    return -1;
  endfunction

  function automatic logic [DW-1:0] expRead(logic [AW-1:0] line, int word,
                                            logic [DW-1:0] fill);
    int s = findSlot(line);
    if (s >= 0 && mMask[s][word]) return mData[s][word];
    return fill;
  endfunction

  task automatic doWrite(logic [AW-1:0] line, int word, logic [DW-1:0] data);
    int s;
    @(negedge clk);
    wrEn = 1; wrLine = line; wrWord = 2'(word); wrData = data;
    @(posedge clk); #1;
    wrEn = 0;
    s = findSlot(line);
    if (s >= 0) begin
      mData[s][word] = data; mMask[s][word] = 1;
    end else if (mCount < NL) begin
      mTag[mCount] = line; mData[mCount][word] = data;
      mMask[mCount][word] = 1; mCount++;
    end else mFull = 1;
  endtask

  task automatic checkRead(logic [AW-1:0] line, int word, string req);
    logic [DW-1:0] fill;
    logic [DW-1:0] e;
    @(negedge clk);
    fill = DW'($urandom);
    rdLine = line; rdWord = 2'(word); fillData = fill;
    #1;
    e = expRead(line, word, fill);
    chk(rdData === e, req, "read data", rdData, e);
  endtask

  task automatic checkFull(string req);
    @(negedge clk);
    chk(full === mFull, req, "full flag", full, mFull);
  endtask

  // Commit the window and check the drain word by word
  task automatic commitDrain(bit sqDuring, bit wrDuring, bit wrWithCommit);
    logic [AW-1:0] eL [NL*NW];
    int eW [NL*NW];
    logic [DW-1:0] eD [NL*NW];
    int n = 0;
    int idx = 0;
    for (int s = 0; s < mCount; s++)
      for (int w = 0; w < NW; w++)
        if (mMask[s][w]) begin
          eL[n] = mTag[s]; eW[n] = w; eD[n] = mData[s][w]; n++;
        end
    @(negedge clk);
    commit = 1;
    if (wrWithCommit) begin
      wrEn = 1; wrLine = 12'hF00; wrWord = 2'd1; wrData = 16'hDEAD;
    end
    @(posedge clk); #1;
    commit = 0; wrEn = 0;
    for (int i = 0; i < NL*NW + 4; i++) begin
      @(negedge clk);
      if (i == 0) chk(full === 1'b0, "R8", "full after commit", full, 0);
      squash = sqDuring && (i == 0);
      if (wrDuring && i == 0) begin
        wrEn = 1; wrLine = 12'hE00; wrWord = 2'd2; wrData = 16'hBEEF;
      end else wrEn = 0;
      if (!drainValid) break;
      if (idx < n) begin
        chk(drainLine === eL[idx], "R5", "drain line", drainLine, eL[idx]);
        chk(drainWord === 2'(eW[idx]), "R5", "drain word", drainWord, eW[idx]);
        chk(drainData === eD[idx], "R6", "drain data", drainData, eD[idx]);
        rdLine = eL[idx]; rdWord = 2'(eW[idx]); fillData = ~eD[idx];
        #1;
        chk(rdData === eD[idx], "R9", "read during drain", rdData, eD[idx]);
      end
      idx++;
    end
    squash = 0; wrEn = 0;
    chk(idx == n, "R5", "drain word count", idx, n);
    @(posedge clk); #1;
    modelClear();
  endtask

  task automatic doSquash(bit withCommit);
    @(negedge clk);
    squash = 1; commit = withCommit;
    @(posedge clk); #1;
    squash = 0; commit = 0;
    modelClear();
    @(negedge clk);
    chk(full === 1'b0, "R8", "full after squash", full, 0);
    chk(drainValid === 1'b0, "R3", "no drain after squash", drainValid, 0);
    @(negedge clk);
    chk(drainValid === 1'b0, "R3", "no drain after squash +1", drainValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'h5EED1);
    modelClear();
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    @(negedge clk);
    chk(full === 1'b0, "R1", "full at reset", full, 0);
    chk(drainValid === 1'b0, "R1", "drainValid at reset", drainValid, 0);
    checkRead(12'h010, 0, "R1");

    // R2 / R6: per-word marks and overwrites
    doWrite(12'h010, 2, 16'h1111);
    checkRead(12'h010, 2, "R2");
    checkRead(12'h010, 1, "R2");
    doWrite(12'h010, 2, 16'h2222);
    doWrite(12'h020, 3, 16'h3333);
    doWrite(12'h010, 0, 16'h4444);
    checkRead(12'h010, 2, "R6");
    checkRead(12'h030, 0, "R2");
    // R4: write in commit cycle and during drain ignored, squash in drain ignored
    commitDrain(1, 1, 1);
    checkRead(12'hF00, 1, "R4");
    checkRead(12'hE00, 2, "R4");
    checkRead(12'h010, 2, "R5");

    // R7: fill the buffer and overflow
    for (int i = 0; i < NL; i++) doWrite(AW'(12'h100 + i), i % NW, DW'(16'hA000 + i));
    checkFull("R7");
    doWrite(12'h1FF, 0, 16'hBAD0);
    checkFull("R7");
    checkRead(12'h1FF, 0, "R7");
    doWrite(12'h101, 3, 16'hC0C0);
    checkRead(12'h101, 3, "R7");
    checkFull("R7");
    commitDrain(0, 0, 0);
    checkFull("R8");

    // R3: squash with commit together wins, no drain
    doWrite(12'h200, 1, 16'h5555);
    doWrite(12'h201, 1, 16'h6666);
    doSquash(1);
    checkRead(12'h200, 1, "R3");

    // Random windows
    for (int win = 0; win < 60; win++) begin
      int ops = 4 + int'($urandom_range(0, 16));
      for (int k = 0; k < ops; k++) begin
        logic [AW-1:0] ln = AW'(12'h300 + $urandom_range(0, 5));
        int wd = int'($urandom_range(0, NW - 1));
        if ($urandom_range(0, 9) < 6) begin
          doWrite(ln, wd, DW'($urandom));
          checkFull("R7");
        end else checkRead(ln, wd, "R2");
      end
      if ($urandom_range(0, 9) < 7) commitDrain(0, 0, 0);
      else doSquash(0);
      checkRead(AW'(12'h300 + $urandom_range(0, 5)), int'($urandom_range(0, NW - 1)), "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule